// File: doc/BRIEF.md
# External Interrupt Pin Trigger Unit

This block turns up to six asynchronous external interrupt pins into clean, clock-domain interrupt requests. Every pin first passes through a two-flop synchroniser. A small per-pin controller then applies the trigger mode that software programmed: high level, low level, rising edge, falling edge or both edges. In the edge modes a detected edge is held until software acknowledges it, and a per-pin mask decides whether the held or level request reaches the output. Each request line can drive a processor interrupt input directly or feed one input of a second-level interrupt controller.

Software programs the unit through a simple synchronous write port and an asynchronous read port. Each 32-bit configuration word holds four pin slots of eight bits. Pins 0 to 3 live in word 0 and pins 4 and 5 in word 1. Each pin's controller is a two-state machine. In PS_IDLE nothing is held. The latch transition moves it to PS_PENDING when an edge of the programmed kind is seen. The acknowledge transition returns it to PS_IDLE when software writes that pin's clear bit. The flush transition forces it to PS_IDLE whenever the pin is in a level mode. The output process computes the request from the state, the mask and the synchronised pin.

Top module: `xpin_unit`

## Requirements
- R1: In a level mode, a change on a pin reaches its request two clock edges later, after the two-flop synchroniser, and not after one.
- R2: With level-select 1, polarity 1 and both-edges 0, an unmasked pin requests while its synchronised input is high.
- R3: With level-select 1 and polarity 0 (the reset setting), an unmasked pin requests while its synchronised input is low.
- R4: With level-select 0, polarity 1 and both-edges 0, a rising edge moves the pin to PS_PENDING. The request is seen three edges after the pin rises and stays held after the pin falls, until the pin is acknowledged.
- R5: With level-select 0, polarity 0 and both-edges 0, a falling edge latches the request in the same way.
- R6: With level-select 0 and both-edges 1, either edge latches the request.
- R7: A pin whose mask bit is 0 never requests. An edge seen while the pin is masked is still held, so unmasking releases it. After reset every pin is masked and nothing is held.
- R8: Writing 1 to a pin's clear bit returns a held edge request to PS_IDLE, and the request drops one edge later. If a new edge is detected in the same cycle, the new edge wins and the pin stays pending.
- R9: Clear bits always read back as 0. In a level mode, writing a clear bit has no effect on the request.
- R10: Level-select 1 together with both-edges 1 is an invalid mode, and such a pin never requests.
- R11: Pin p sits in word p/4 (address 0 or 1), in byte p mod 4. Within the byte, bit 0 is clear, bit 1 is mask, bit 2 is polarity, bit 3 is level-select and bit 4 is both-edges. All other bits, and the bytes of pins that do not exist, read 0. After reset word 0 reads 0x08080808 and word 1 reads 0x00000808.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Raw external interrupt pins, asynchronous |
| wr_en | input | 1 | Configuration word write strobe |
| wr_addr | input | ADDR_W | Configuration word index for writes |
| wr_data | input | 32 | Configuration write data |
| rd_addr | input | ADDR_W | Configuration word index for reads |
| rd_data | output | 32 | Configuration read data, combinational |
| irq_o | output | NUM_PINS | Per-pin interrupt request |

## Verification
The random part of the bench toggles pins freely while rewriting whole configuration words with random content. Every mode, the invalid combination, masking and clears therefore occur in every phase relative to edges, including a clear that lands in the same cycle as a new edge. Comparing each pin's request every cycle against a model built from the requirements separates level modes from latched edge modes, rising from falling from both, and a one-cycle error in the synchroniser or edge pipeline. Directed cases pin down the exact two-edge level latency, that a request stays held after the pin returns to its idle value, that a clear drops a held request, and the reset readback.

// File: rtl/xpin_pkg.sv
package xpin_pkg;

    // bit positions inside one 8-bit pin slot
    localparam int FB_CLR  = 0;
    localparam int FB_MASK = 1;
    localparam int FB_POL  = 2;
    localparam int FB_LVL  = 3;
    localparam int FB_BOTH = 4;

    typedef struct packed {
        logic both;
        logic lvl;
        logic pol;
        logic mask;
    } xpin_cfg_t;

    localparam xpin_cfg_t CFG_RESET = '{both: 1'b0, lvl: 1'b1, pol: 1'b0, mask: 1'b0};

    typedef enum logic {
        PS_IDLE    = 1'b0,
        PS_PENDING = 1'b1
    } pin_state_e;

endpackage

// File: rtl/xpin_sync.sv
module xpin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xpin_chan.sv
module xpin_chan
    import xpin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_i,
    input  xpin_cfg_t cfg_i,
    input  logic      clr_i,
    output logic      irq_o
);
    logic       pin_s;
    logic       pin_prev_q;
    logic       hit;
    pin_state_e state_q, state_nx;

    xpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_prev_q <= 1'b0;
        else        pin_prev_q <= pin_s;
    end

    // edge of the programmed kind seen this cycle
    always_comb begin
        if (cfg_i.lvl)       hit = 1'b0;
        else if (cfg_i.both) hit = pin_s ^ pin_prev_q;
        else if (cfg_i.pol)  hit = pin_s & ~pin_prev_q;
        else                 hit = ~pin_s & pin_prev_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_nx;
    end

    // transitions: latch, acknowledge, flush
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            PS_IDLE: begin
                if (hit) state_nx = PS_PENDING;                 // latch
            end
            PS_PENDING: begin
                if (cfg_i.lvl)          state_nx = PS_IDLE;     // flush
                else if (!hit && clr_i) state_nx = PS_IDLE;     // acknowledge
            end
            default: state_nx = PS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        if (cfg_i.lvl)
            irq_o = cfg_i.mask & ~cfg_i.both & (pin_s == cfg_i.pol);
        else
            irq_o = cfg_i.mask & (state_q == PS_PENDING);
    end

    AST_RISE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.lvl && !cfg_i.both && cfg_i.pol && pin_s && !pin_prev_q) |=> (state_q == PS_PENDING)); // R4
    AST_HELD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PENDING && !cfg_i.lvl && !clr_i) |=> (state_q == PS_PENDING)); // R8
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PENDING && !cfg_i.lvl && clr_i && !hit) |=> (state_q == PS_IDLE)); // R8
    AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.lvl && cfg_i.both) |-> !irq_o); // R10
endmodule

// File: rtl/xpin_unit.sv
module xpin_unit
    import xpin_pkg::*;
#(
    parameter int NUM_PINS    = 6,
    parameter int SYNC_STAGES = 2,
    parameter int REG_W       = 32,
    parameter int SLOT_W      = 8,
    localparam int SLOTS      = REG_W / SLOT_W,
    localparam int NUM_REGS   = (NUM_PINS + SLOTS - 1) / SLOTS,
    localparam int ADDR_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic [NUM_PINS-1:0] irq_o
);
    localparam logic [SLOT_W-1:0] SLOT_USED = SLOT_W'(6'b011111);

    xpin_cfg_t           cfg_q [NUM_PINS];
    logic [NUM_PINS-1:0] clr;
    logic                wr_spare_unused;

    assign wr_spare_unused = ^(wr_data & ~{SLOTS{SLOT_USED}});

    // configuration write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PINS; p++) cfg_q[p] <= CFG_RESET;
        end else if (wr_en) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (wr_addr == ADDR_W'(p / SLOTS)) begin
                    cfg_q[p].mask <= wr_data[(p % SLOTS) * SLOT_W + FB_MASK];
                    cfg_q[p].pol  <= wr_data[(p % SLOTS) * SLOT_W + FB_POL];
                    cfg_q[p].lvl  <= wr_data[(p % SLOTS) * SLOT_W + FB_LVL];
                    cfg_q[p].both <= wr_data[(p % SLOTS) * SLOT_W + FB_BOTH];
                end
            end
        end
    end

    // self-resetting clear strobes
    always_comb begin
        for (int p = 0; p < NUM_PINS; p++)
            clr[p] = wr_en && (wr_addr == ADDR_W'(p / SLOTS))
                     && wr_data[(p % SLOTS) * SLOT_W + FB_CLR];
    end

    // readback, clear bits read 0
    always_comb begin
        rd_data = '0;
        for (int s = 0; s < SLOTS; s++) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if ((p % SLOTS) == s && rd_addr == ADDR_W'(p / SLOTS)) begin
                    rd_data[s * SLOT_W + FB_MASK] = cfg_q[p].mask;
                    rd_data[s * SLOT_W + FB_POL]  = cfg_q[p].pol;
                    rd_data[s * SLOT_W + FB_LVL]  = cfg_q[p].lvl;
                    rd_data[s * SLOT_W + FB_BOTH] = cfg_q[p].both;
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        xpin_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (pin_i[g]),
            .cfg_i (cfg_q[g]),
            .clr_i (clr[g]),
            .irq_o (irq_o[g])
        );

        AST_MASK_WRITE_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(g / SLOTS) && !wr_data[(g % SLOTS) * SLOT_W + FB_MASK])
            |=> !irq_o[g]); // R7
    end
endmodule

// File: tb/sim_xpin_unit.sv
`timescale 1ns/1ps
module sim_xpin_unit;
    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_i = '0;
    logic          wr_en = 1'b0;
    logic [0:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [0:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NP-1:0] irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    xpin_unit u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    // requirement model
    bit m_mask[NP], m_pol[NP], m_lvl[NP], m_both[NP];
    bit m_sa[NP], m_sb[NP], m_pv[NP], m_pend[NP];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                m_mask[p] = 0; m_pol[p] = 0; m_lvl[p] = 1; m_both[p] = 0;
                m_sa[p] = 0; m_sb[p] = 0; m_pv[p] = 0; m_pend[p] = 0;
            end
        end else begin
            for (int p = 0; p < NP; p++) begin
                bit hit, sel, clr;
                sel = wr_en && (int'(wr_addr) == p / 4);
                clr = sel && wr_data[(p % 4) * 8];
                if (m_lvl[p])       hit = 0;
                else if (m_both[p]) hit = m_sb[p] ^ m_pv[p];
                else if (m_pol[p])  hit = m_sb[p] & ~m_pv[p];
                else                hit = ~m_sb[p] & m_pv[p];
                if (m_lvl[p])  m_pend[p] = 0;
                else if (hit)  m_pend[p] = 1;
                else if (clr)  m_pend[p] = 0;
                m_pv[p] = m_sb[p]; m_sb[p] = m_sa[p]; m_sa[p] = pin_i[p];
                if (sel) begin
                    m_mask[p] = wr_data[(p % 4) * 8 + 1];
                    m_pol[p]  = wr_data[(p % 4) * 8 + 2];
                    m_lvl[p]  = wr_data[(p % 4) * 8 + 3];
                    m_both[p] = wr_data[(p % 4) * 8 + 4];
                end
            end
        end
    end

    function automatic bit exp_irq(int p);
        if (m_lvl[p]) return m_mask[p] & ~m_both[p] & (m_sb[p] == m_pol[p]);
        return m_mask[p] & m_pend[p];
    endfunction

    function automatic logic [31:0] exp_rd(int a);
        logic [31:0] v = '0;
        for (int p = 0; p < NP; p++)
            if (p / 4 == a)
                v[(p % 4) * 8 +: 8] = {3'b000, m_both[p], m_lvl[p], m_pol[p], m_mask[p], 1'b0};
        return v;
    endfunction

    function automatic string mode_tag(int p);
        if (m_lvl[p] && m_both[p]) return "R10";
        if (!m_mask[p])            return "R7";
        if (m_lvl[p])              return m_pol[p] ? "R2" : "R3";
        if (m_both[p])             return "R6";
        return m_pol[p] ? "R4" : "R5";
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        for (int p = 0; p < NP; p++) check(mode_tag(p), 32'(irq_o[p]), 32'(exp_irq(p)));
        for (int a = 0; a < 2; a++) begin
            rd_addr = a[0:0];
            #0.2;
            check("R11", rd_data, exp_rd(a));
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a[0:0]; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_data = '0;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        void'($urandom(32'd1234));
        step(3);
        // reset state
        rd_addr = 0; #0.2; check("R11", rd_data, 32'h08080808);
        rd_addr = 1; #0.2; check("R11", rd_data, 32'h00000808);
        check("R7", 32'(irq_o), 32'h0);
        rst_n = 1;
        step(2);
        check("R7", 32'(irq_o), 32'h0);

        // R3: default active-low level, unmask pin 0 while pin low
        wr(0, 32'h0808080A);
        step(1);
        check("R3", 32'(irq_o[0]), 32'h1);

        // R1: active-high on pin 1, two-edge latency
        wr(0, 32'h08080E0A);
        pin_i[1] = 1'b1;
        @(negedge clk); check("R1", 32'(irq_o[1]), 32'h0);
        @(negedge clk); check("R1", 32'(irq_o[1]), 32'h1);
        pin_i[1] = 1'b0;
        step(2);

        // R4 + R8: rising edge on pin 4, held after pin falls, then cleared
        wr(1, 32'h00000806);
        pin_i[4] = 1'b1;
        step(1); pin_i[4] = 1'b0;
        step(2);
        check("R4", 32'(irq_o[4]), 32'h1);
        step(3);
        check("R4", 32'(irq_o[4]), 32'h1);
        wr(1, 32'h00000807);
        check("R8", 32'(irq_o[4]), 32'h0);

        // R9: clear in level mode leaves request, clear reads 0
        wr(0, 32'h08080E0B);
        check("R9", 32'(irq_o[0]), 32'h1);
        rd_addr = 0; #0.2; check("R9", 32'(rd_data[0]), 32'h0);

        // R10: invalid mode on pin 5
        wr(1, 32'h00001A06);
        pin_i[5] = 1'b1; step(3);
        check("R10", 32'(irq_o[5]), 32'h0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            check_all();
            wr_en = 1'b0;
            for (int p = 0; p < NP; p++)
                if ($urandom_range(3) == 0) pin_i[p] = ~pin_i[p];
            if ($urandom_range(5) == 0) begin
                logic [31:0] d = $urandom;
                for (int s = 0; s < 4; s++)
                    if ($urandom_range(3) != 0) d[s * 8 + 1] = 1'b1;
                wr_en = 1'b1; wr_addr = 1'($urandom_range(1)); wr_data = d;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        check_all();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule